// File: doc/BRIEF.md
# Staged Power-Down Clock Sequencer

This controller sits between a clock synthesizer's clock sources and its output pins. It gates the outputs group by group when an active-low power-down request arrives, and releases them in stages when the request goes away. Every group of single-ended outputs is parked low. The differential CPU pairs are parked with the true leg held high and the complement leg left undriven. Once every group has stopped, the block raises a sleep request toward the PLL stages and the crystal oscillator.

The stop order and the release order are not mirror images. Outputs stop in this order: PCI, the buffered 66 MHz outputs, the CPU-PLL outputs (CPU pairs and driven 66 MHz), the 48 MHz pair, and finally the 14.318 MHz reference. On wake-up the block does nothing until the PLL reports lock. It then releases the CPU pairs, the driven 66 MHz outputs and one chosen buffered 66 MHz output together. After a programmable gap it releases the remaining buffered outputs, then PCI, then the 48 MHz and reference outputs.

The whole block runs in the fastest (CPU) clock domain. Each group's clock source enters as a data input that is synchronous to that clock, and each gate changes state only while its source sits at the parking level.

Top module: `clk_pwrdn_sequencer`

## Requirements
- R1: The power-down request takes effect only after `pwrdn_n` has been sampled low on two consecutive rising edges of `clk`. It is withdrawn only after `pwrdn_n` has been sampled high on two consecutive edges. A single-cycle low pulse changes no output.
- R2: On entry, groups stop in this order: PCI, buffered 66 MHz, CPU pairs with driven 66 MHz, 48 MHz USB/DOT, reference. Once a group has been seen stopped, no group that stops earlier in this order runs again during that entry.
- R3: `osc_pll_sleep` rises only after every group has stopped, and it stays high until the request is withdrawn. While it is high, no output runs.
- R4: A gated single-ended output is held at 0. Its gate changes only while its source clock is low, so no shortened high pulse appears.
- R5: A stopped CPU pair drives `cpu_t`=1, `cpu_c`=0 and `cpu_c_oe`=0. A running pair drives `cpu_c_oe`=1 and `cpu_c` = NOT `cpu_t`. Its gate changes only while `cpu_src` is high.
- R6: After the request is withdrawn, no output runs while `pll_locked` is 0.
- R7: The first release stage frees the CPU pairs, both driven 66 MHz outputs and buffered output index `B66_EARLY` (1 by default). All three are running before any other buffered 66 MHz output.
- R8: The other buffered 66 MHz outputs are released `GAP_CYCLES` clock cycles after the first stage has fully started. Elaboration rejects a gap outside 30 µs to 400 µs at `CLK_MHZ`.
- R9: After the gap, release proceeds as: remaining buffered 66 MHz, then PCI, then USB/DOT together with the reference. Once a later stage is seen running, no earlier stage is seen gated.
- R10: If the request returns during release, the block restarts the entry sequence from its first stage. Groups that were already released stop again, groups that were never released stay stopped, and `osc_pll_sleep` rises again.
- R11: After reset, every group runs and `osc_pll_sleep` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-domain clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwrdn_n | input | 1 | Active-low power-down request |
| pll_locked | input | 1 | PLL lock indication, 1 = stable frequency |
| pci_src | input | 1 | PCI group source clock |
| b66_src | input | 1 | Buffered 66 MHz group source clock |
| cpu_src | input | 1 | CPU pair source clock (true phase) |
| d66_src | input | 1 | Driven 66 MHz group source clock |
| f48_src | input | 1 | 48 MHz source clock |
| ref_src | input | 1 | 14.318 MHz reference source |
| pci_clk | output | N_PCI | Gated PCI outputs |
| b66_clk | output | N_B66 | Gated buffered 66 MHz outputs |
| cpu_t | output | N_CPU | CPU pair true legs |
| cpu_c | output | N_CPU | CPU pair complement legs |
| cpu_c_oe | output | N_CPU | Complement drive enable, 0 = undriven |
| d66_clk | output | N_D66 | Gated driven 66 MHz outputs |
| usb_clk | output | 1 | Gated 48 MHz USB output |
| dot_clk | output | 1 | Gated 48 MHz DOT output |
| ref_clk | output | 1 | Gated reference output |
| osc_pll_sleep | output | 1 | Low-power request to PLL and oscillator |

## Verification
The hardest state to reach is a power-down request that comes back during the release gap. By then the early buffered output and the CPU pairs are running while their siblings are still parked, and an ordinary stop/start cycle passes through that window without lingering. The stimulus waits at the ports until the CPU pair is first seen toggling, waits a short while longer so that the block is inside the gap, and then lowers the request. It then checks that the block parks again without ever releasing the late buffered outputs. Source periods and lock delays are drawn at random so that each gate lands on a different source phase in every cycle.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
   localparam int NLANE  = 7;
   localparam int LN_PCI  = 0;
   localparam int LN_BUF  = 1;
   localparam int LN_BUFE = 2;
   localparam int LN_CPU  = 3;
   localparam int LN_DRV  = 4;
   localparam int LN_F48  = 5;
   localparam int LN_REF  = 6;
   localparam int N_DOWN  = 5;
   localparam int N_UP    = 4;
   localparam int STG_W   = 3;

   typedef logic [NLANE-1:0] lane_vec_t;

   typedef enum logic [2:0] {
      ST_RUN, ST_DOWN, ST_SLEEP, ST_WAKE, ST_UP, ST_GAP
   } seq_st_e;

   // lanes gated by each entry stage
   function automatic lane_vec_t down_mask(input logic [STG_W-1:0] s);
      lane_vec_t m;
      m = '0;
      case (s)
         3'd0: m[LN_PCI] = 1'b1;
         3'd1: begin m[LN_BUF] = 1'b1; m[LN_BUFE] = 1'b1; end
         3'd2: begin m[LN_CPU] = 1'b1; m[LN_DRV] = 1'b1; end
         3'd3: m[LN_F48] = 1'b1;
         3'd4: m[LN_REF] = 1'b1;
         default: m = '0;
      endcase
      return m;
   endfunction

   // lanes released by each exit stage
   function automatic lane_vec_t up_mask(input logic [STG_W-1:0] s);
      lane_vec_t m;
      m = '0;
      case (s)
         3'd0: begin m[LN_CPU] = 1'b1; m[LN_DRV] = 1'b1; m[LN_BUFE] = 1'b1; end
         3'd1: m[LN_BUF] = 1'b1;
         3'd2: m[LN_PCI] = 1'b1;
         3'd3: begin m[LN_F48] = 1'b1; m[LN_REF] = 1'b1; end
         default: m = '0;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/pdseq_req_filter.sv
module pdseq_req_filter (
   input  logic clk,
   input  logic rst_n,
   input  logic pwrdn_n,
   output logic req
);
   logic prev_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_n <= 1'b1;
         req    <= 1'b0;
      end else begin
         prev_n <= pwrdn_n;
         if (!pwrdn_n && !prev_n)
            req <= 1'b1;
         else if (pwrdn_n && prev_n)
            req <= 1'b0;
      end
   end

   // R1
   req_rise_two_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> (!$past(pwrdn_n) && !$past(pwrdn_n, 2)));
   // R1
   req_fall_two_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req) |-> ($past(pwrdn_n) && $past(pwrdn_n, 2)));
endmodule

// File: rtl/pdseq_gate_lane.sv
module pdseq_gate_lane #(
   parameter bit PARK_HIGH = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src,
   input  logic want,
   output logic en
);
   logic safe;

   generate
      if (PARK_HIGH) begin : g_park_hi
         assign safe = src;
         // R5
         pair_gate_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(en) |-> $past(src));
      end else begin : g_park_lo
         assign safe = ~src;
         // R4
         se_gate_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(en) |-> !$past(src));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         en <= 1'b1;
      else if (safe)
         en <= want;
   end
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
   import pdseq_pkg::*;
#(
   parameter int GAP_CYCLES = 4000
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      req,
   input  logic      lock,
   input  lane_vec_t en,
   output lane_vec_t want,
   output logic      sleep
);
   localparam int CNT_W = $clog2(GAP_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GAP_CYCLES - 1);

   seq_st_e          st;
   logic [STG_W-1:0] stg;
   logic [CNT_W-1:0] cnt;
   lane_vec_t        dm, um;
   logic             down_done, up_done;

   assign dm        = down_mask(stg);
   assign um        = up_mask(stg);
   assign down_done = ((en & dm) == '0) && ((want & dm) == '0);
   assign up_done   = ((en & um) == um) && ((want & um) == um);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_RUN;
         stg   <= '0;
         cnt   <= '0;
         want  <= '1;
         sleep <= 1'b0;
      end else begin
         case (st)
            ST_RUN: if (req) begin
               st  <= ST_DOWN;
               stg <= '0;
            end
            ST_DOWN: begin
               want <= want & ~dm;
               if (down_done) begin
                  if (stg == STG_W'(N_DOWN - 1)) begin
                     st    <= ST_SLEEP;
                     sleep <= 1'b1;
                  end else begin
                     stg <= stg + 1'b1;
                  end
               end
            end
            ST_SLEEP: if (!req) begin
               sleep <= 1'b0;
               st    <= ST_WAKE;
            end
            ST_WAKE: begin
               if (req) begin
                  st  <= ST_DOWN;
                  stg <= '0;
               end else if (lock) begin
                  st  <= ST_UP;
                  stg <= '0;
               end
            end
            ST_UP: begin
               if (req) begin
                  st  <= ST_DOWN;
                  stg <= '0;
               end else begin
                  want <= want | um;
                  if (up_done) begin
                     if (stg == '0) begin
                        st  <= ST_GAP;
                        cnt <= '0;
                     end else if (stg == STG_W'(N_UP - 1)) begin
                        st <= ST_RUN;
                     end else begin
                        stg <= stg + 1'b1;
                     end
                  end
               end
            end
            ST_GAP: begin
               if (req) begin
                  st  <= ST_DOWN;
                  stg <= '0;
               end else if (cnt == CNT_LAST) begin
                  st  <= ST_UP;
                  stg <= STG_W'(1);
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   // R3
   sleep_all_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> (en == '0));
   // R6
   wait_lock_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAKE) |-> (en == '0));
   // R7
   late_buf_after_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en[LN_BUF] |-> (en[LN_CPU] && en[LN_DRV]));
   // R9
   pci_after_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en[LN_PCI] |-> en[LN_BUF]);
   // R10
   reenter_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((st == ST_UP) || (st == ST_GAP)) && req) |=> ((st == ST_DOWN) && (stg == '0)));
endmodule

// File: rtl/clk_pwrdn_sequencer.sv
module clk_pwrdn_sequencer
   import pdseq_pkg::*;
#(
   parameter int N_PCI      = 10,
   parameter int N_B66      = 3,
   parameter int B66_EARLY  = 1,
   parameter int N_CPU      = 3,
   parameter int N_D66      = 2,
   parameter int CLK_MHZ    = 100,
   parameter int GAP_CYCLES = 4000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwrdn_n,
   input  logic             pll_locked,
   input  logic             pci_src,
   input  logic             b66_src,
   input  logic             cpu_src,
   input  logic             d66_src,
   input  logic             f48_src,
   input  logic             ref_src,
   output logic [N_PCI-1:0] pci_clk,
   output logic [N_B66-1:0] b66_clk,
   output logic [N_CPU-1:0] cpu_t,
   output logic [N_CPU-1:0] cpu_c,
   output logic [N_CPU-1:0] cpu_c_oe,
   output logic [N_D66-1:0] d66_clk,
   output logic             usb_clk,
   output logic             dot_clk,
   output logic             ref_clk,
   output logic             osc_pll_sleep
);
   localparam int GAP_MIN = 30 * CLK_MHZ;
   localparam int GAP_MAX = 400 * CLK_MHZ;

   initial begin
      // R8
      gap_window_chk: assert (GAP_CYCLES > GAP_MIN && GAP_CYCLES < GAP_MAX)
         else $error("release gap outside the 30 to 400 us window");
      early_idx_chk: assert (B66_EARLY >= 0 && B66_EARLY < N_B66)
         else $error("early buffered index out of range");
      widths_chk: assert (N_PCI > 0 && N_CPU > 0 && N_D66 > 0)
         else $error("output group widths must be positive");
   end

   logic      req;
   lane_vec_t want, en, lane_src;

   pdseq_req_filter u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .pwrdn_n (pwrdn_n),
      .req     (req)
   );

   pdseq_ctrl #(.GAP_CYCLES(GAP_CYCLES)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req),
      .lock  (pll_locked),
      .en    (en),
      .want  (want),
      .sleep (osc_pll_sleep)
   );

   assign lane_src[LN_PCI]  = pci_src;
   assign lane_src[LN_BUF]  = b66_src;
   assign lane_src[LN_BUFE] = b66_src;
   assign lane_src[LN_CPU]  = cpu_src;
   assign lane_src[LN_DRV]  = d66_src;
   assign lane_src[LN_F48]  = f48_src;
   assign lane_src[LN_REF]  = ref_src;

   generate
      for (genvar g = 0; g < NLANE; g++) begin : g_lane
         pdseq_gate_lane #(.PARK_HIGH(g == LN_CPU)) u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (lane_src[g]),
            .want  (want[g]),
            .en    (en[g])
         );
      end

      for (genvar b = 0; b < N_B66; b++) begin : g_b66
         if (b == B66_EARLY) begin : g_early
            assign b66_clk[b] = b66_src & en[LN_BUFE];
         end else begin : g_late
            assign b66_clk[b] = b66_src & en[LN_BUF];
         end
      end
   endgenerate

   assign pci_clk  = {N_PCI{pci_src & en[LN_PCI]}};
   assign cpu_t    = en[LN_CPU] ? {N_CPU{cpu_src}} : {N_CPU{1'b1}};
   assign cpu_c    = {N_CPU{en[LN_CPU] & ~cpu_src}};
   assign cpu_c_oe = {N_CPU{en[LN_CPU]}};
   assign d66_clk  = {N_D66{d66_src & en[LN_DRV]}};
   assign usb_clk  = f48_src & en[LN_F48];
   assign dot_clk  = f48_src & en[LN_F48];
   assign ref_clk  = ref_src & en[LN_REF];
endmodule

// File: tb/tb_clk_pwrdn_sequencer.sv
module tb_clk_pwrdn_sequencer;
   localparam int GAP = 4000;
   localparam int NP = 10, NB = 3, NC = 3, ND = 2;
   // bench lane order: 0 PCI, 1 late buffered, 2 early buffered, 3 CPU, 4 driven 66, 5 48 MHz, 6 REF
   localparam int DSTG [7] = '{0, 1, 1, 2, 2, 3, 4};
   localparam int USTG [7] = '{2, 1, 0, 0, 0, 3, 3};

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n, pwrdn_n, pll_locked;
   logic [5:0] srcv = '0;
   logic [NP-1:0] pci_clk;
   logic [NB-1:0] b66_clk;
   logic [NC-1:0] cpu_t, cpu_c, cpu_c_oe;
   logic [ND-1:0] d66_clk;
   logic usb_clk, dot_clk, ref_clk, osc_pll_sleep;

   clk_pwrdn_sequencer #(.N_PCI(NP), .N_B66(NB), .B66_EARLY(1), .N_CPU(NC),
                         .N_D66(ND), .CLK_MHZ(100), .GAP_CYCLES(GAP)) dut (
      .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .pll_locked(pll_locked),
      .pci_src(srcv[0]), .b66_src(srcv[1]), .cpu_src(srcv[2]), .d66_src(srcv[3]),
      .f48_src(srcv[4]), .ref_src(srcv[5]),
      .pci_clk(pci_clk), .b66_clk(b66_clk), .cpu_t(cpu_t), .cpu_c(cpu_c),
      .cpu_c_oe(cpu_c_oe), .d66_clk(d66_clk), .usb_clk(usb_clk), .dot_clk(dot_clk),
      .ref_clk(ref_clk), .osc_pll_sleep(osc_pll_sleep));

   // source clocks: random half periods of 1..4 cycles
   int hp [6];
   int cnt [6] = '{default: 0};
   always @(posedge clk) begin
      #1;
      for (int i = 0; i < 6; i++) begin
         if (cnt[i] + 1 >= hp[i]) begin
            cnt[i] = 0;
            srcv[i] = ~srcv[i];
         end else begin
            cnt[i] = cnt[i] + 1;
         end
      end
   end

   int checks = 0, errors = 0;
   int epoch = 0;
   logic mon_down = 0, mon_up = 0, mon_nolock = 0, mon_parked = 0;

   // monitor state, written only here
   int seen_epoch = -1, cyc = 0, maxg = -1, maxa = -1;
   int first_act [7];
   logic [6:0] act, gat, act_seen;
   logic slp_seen;
   int down_err = 0, up_err = 0, lock_err = 0, park_err = 0, pair_err = 0;

   always @(negedge clk) begin
      cyc++;
      act[0] = |pci_clk;                 gat[0] = srcv[0] && !(|pci_clk);
      act[1] = b66_clk[0] | b66_clk[2];  gat[1] = srcv[1] && !(b66_clk[0] | b66_clk[2]);
      act[2] = b66_clk[1];               gat[2] = srcv[1] && !b66_clk[1];
      act[3] = !(&cpu_t);                gat[3] = !srcv[2] && (&cpu_t);
      act[4] = |d66_clk;                 gat[4] = srcv[3] && !(|d66_clk);
      act[5] = usb_clk | dot_clk;        gat[5] = srcv[4] && !(usb_clk | dot_clk);
      act[6] = ref_clk;                  gat[6] = srcv[5] && !ref_clk;
      if (epoch != seen_epoch) begin
         seen_epoch = epoch;
         maxg = -1; maxa = -1; act_seen = '0; slp_seen = 1'b0;
         for (int l = 0; l < 7; l++) first_act[l] = -1;
      end
      act_seen = act_seen | act;
      if (osc_pll_sleep) slp_seen = 1'b1;
      if (mon_down) begin
         for (int l = 0; l < 7; l++) if (gat[l] && DSTG[l] > maxg) maxg = DSTG[l];
         for (int l = 0; l < 7; l++) if (act[l] && DSTG[l] < maxg) down_err++;
      end
      if (mon_up) begin
         for (int l = 0; l < 7; l++)
            if (act[l]) begin
               if (first_act[l] < 0) first_act[l] = cyc;
               if (USTG[l] > maxa) maxa = USTG[l];
            end
         for (int l = 0; l < 7; l++) if (gat[l] && USTG[l] < maxa) up_err++;
      end
      if (mon_nolock && (|act)) lock_err++;
      if ((mon_parked || osc_pll_sleep) && ((|act) || (|cpu_c_oe))) park_err++;
      for (int i = 0; i < NC; i++) begin
         if (!cpu_c_oe[i]) begin
            if (!(cpu_t[i] && !cpu_c[i])) pair_err++;
         end else if (cpu_c[i] !== ~cpu_t[i]) pair_err++;
      end
   end

   task automatic check(input bit ok, input string tag, input longint a, input longint e);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, a, e);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wait_sleep(input logic lvl, input int maxc, output int n);
      n = 0;
      while (osc_pll_sleep !== lvl && n < maxc) begin tick(1); n++; end
   endtask

   task automatic new_periods();
      for (int i = 0; i < 6; i++) hp[i] = 1 + int'($urandom % 4);
   endtask

   task automatic power_cycle(input bit reenter);
      int n, d0, u0, l0, p0, q0, diff;
      new_periods();
      epoch++;
      d0 = down_err; p0 = park_err; q0 = pair_err;
      mon_down = 1;
      pwrdn_n = 0;
      wait_sleep(1'b1, 600, n);
      check(osc_pll_sleep === 1'b1, "R3 sleep raised after entry", osc_pll_sleep, 1);
      mon_down = 0;
      check(down_err == d0, "R2 entry order violations", down_err - d0, 0);
      pll_locked = 0;
      mon_parked = 1;
      tick(30);
      check(park_err == p0, "R4 outputs parked during sleep", park_err - p0, 0);
      check(cpu_t == '1 && cpu_c == '0 && cpu_c_oe == '0, "R5 pair parked true-high",
            {cpu_t, cpu_c, cpu_c_oe}, {{NC{1'b1}}, {2*NC{1'b0}}});
      pwrdn_n = 1;
      wait_sleep(1'b0, 20, n);
      check(n >= 2 && n <= 6, "R1 release needs two high samples", n, 3);
      mon_parked = 0;
      epoch++;
      l0 = lock_err; u0 = up_err;
      mon_nolock = 1;
      mon_up = 1;
      tick(1);
      tick(20 + int'($urandom % 60));
      mon_nolock = 0;
      check(lock_err == l0, "R6 no output before lock", lock_err - l0, 0);
      pll_locked = 1;
      if (reenter) begin
         n = 0;
         while (first_act[3] < 0 && n < 200) begin tick(1); n++; end
         check(first_act[3] >= 0, "R7 CPU pair released first", first_act[3], 1);
         tick(100);
         mon_up = 0;
         pwrdn_n = 0;
         wait_sleep(1'b1, 600, n);
         check(osc_pll_sleep === 1'b1, "R10 sleep again after re-entry", osc_pll_sleep, 1);
         check(first_act[1] < 0 && first_act[0] < 0, "R10 unreleased groups stayed parked",
               first_act[1], -1);
         pll_locked = 0;
         p0 = park_err;
         tick(20);
         check(park_err == p0, "R10 all parked after re-entry", park_err - p0, 0);
         pwrdn_n = 1;
         wait_sleep(1'b0, 20, n);
         epoch++;
         u0 = up_err;
         mon_up = 1;
         tick(10);
         pll_locked = 1;
      end
      n = 0;
      while ((first_act[0] < 0 || first_act[1] < 0 || first_act[5] < 0 || first_act[6] < 0)
             && n < GAP + 800) begin tick(1); n++; end
      check(first_act[0] >= 0 && first_act[5] >= 0 && first_act[6] >= 0,
            "R9 every group released", n, GAP);
      check(first_act[2] < first_act[1] && first_act[3] < first_act[1] && first_act[4] < first_act[1],
            "R7 early buffered and CPU ahead of siblings", first_act[2], first_act[1]);
      diff = first_act[1] - first_act[3];
      check(diff >= GAP - 10 && diff <= GAP + 40, "R8 gap length in cycles", diff, GAP);
      check(diff * 10 > 30000 && diff * 10 < 400000, "R8 gap inside 30..400 us", diff * 10, 40000);
      check(up_err == u0, "R9 release order violations", up_err - u0, 0);
      check(pair_err == q0, "R5 pair leg consistency", pair_err - q0, 0);
      mon_up = 0;
      tick(5);
   endtask

   initial begin
      int n;
      void'($urandom(32'd20240611));
      new_periods();
      rst_n = 0; pwrdn_n = 1; pll_locked = 1;
      tick(5);
      rst_n = 1;
      tick(2);
      epoch++;
      tick(40);
      check(osc_pll_sleep === 1'b0, "R11 sleep low after reset", osc_pll_sleep, 0);
      check(act_seen == 7'h7f, "R11 all groups run after reset", act_seen, 7'h7f);
      // single-cycle glitch is filtered out
      epoch++;
      tick(1);
      pwrdn_n = 0;
      tick(1);
      pwrdn_n = 1;
      tick(60);
      check(slp_seen == 1'b0, "R1 one-cycle pulse ignored (sleep)", slp_seen, 0);
      check(act_seen == 7'h7f, "R1 one-cycle pulse ignored (outputs)", act_seen, 7'h7f);
      // two-cycle pulse is enough to run a full sequence
      epoch++;
      tick(1);
      pwrdn_n = 0;
      tick(2);
      pwrdn_n = 1;
      wait_sleep(1'b1, 600, n);
      check(osc_pll_sleep === 1'b1 || slp_seen, "R1 two low samples start entry", n, 50);
      n = 0;
      epoch++;
      tick(1);
      while (act_seen != 7'h7f && n < GAP + 800) begin tick(1); n++; end
      check(act_seen == 7'h7f, "R9 outputs resume after short pulse", act_seen, 7'h7f);
      for (int k = 0; k < 3; k++) power_cycle(1'b0);
      power_cycle(1'b1);
      power_cycle(1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
         $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
         $finish;
      end
   end
endmodule